// File: doc/BRIEF.md
# Byte-Wide Host to Word-Wide ATA Drive Bridge

This block lets a host with an 8-bit I/O bus reach a drive whose register interface follows the ATA convention and carries 16-bit data. The block claims sixteen consecutive I/O addresses. The base of that window is picked from thirty-two aligned positions by a select input. Byte-wide command-block registers pass straight through. The 16-bit data register is split: its low half travels through the data offset, and its high half sits in a holding latch that the host reads and writes at its own offset. The device control register and the alternate status register share one further offset. A host read of that offset returns alternate status, and a host write of it reaches device control.

Each request that reaches the drive runs the same fixed sequence: one clock of address and chip-select setup, a strobe held low for `STROBE_CYC` clocks, then one clock of hold. The host sees `hostReady` low until the sequence ends. Requests that are served locally take no drive cycle: latch accesses, and reads of the unused offsets. Their read answer appears on the cycle after the request. `hostDataOe` marks the only cycles in which the block drives the host read bus.

Top module: `narrow_ata_bridge`

## Requirements
- R1: The window is the sixteen addresses whose bits [9:4] equal 0x20 + `baseSel`. So `baseSel` 0x00 gives base 0x200, 0x10 gives 0x300 and 0x1F gives 0x3F0. An access outside the window causes no drive cycle, never raises `hostDataOe` and leaves the latch unchanged.
- R2: A host write to offset 0 makes one drive write with CS0 and address 0. The word carries the written byte in bits [7:0] and the latch contents in bits [15:8].
- R3: A host read of offset 0 makes one drive read with CS0 and address 0. The host receives bits [7:0] of the drive word, and bits [15:8] are stored in the latch.
- R4: Offset 8 reads and writes the latch with no drive cycle. A read answers on the cycle after the request, and `hostReady` stays high.
- R5: Offsets 1 to 7 assert CS0 with drive address equal to the offset. A write puts the byte on bits [7:0] and 0x00 on bits [15:8]. A read returns bits [7:0] and leaves the latch alone.
- R6: Offset 0xE asserts CS1 with drive address 6. A write there reaches device control, and a read returns alternate status.
- R7: A read of offset 0x9 to 0xD or 0xF returns 0xFF with no drive cycle. A write to those offsets has no effect.
- R8: Every drive access is one setup clock with a chip select and strobes high, then `STROBE_CYC` clocks with exactly one strobe low, then one hold clock. `hostReady` is low for `STROBE_CYC`+2 clocks after the request edge.
- R9: On a drive read, the data is taken on the clock edge at which the read strobe rises. The drive bus is never driven while the read strobe is low.
- R10: After reset the latch holds 0x00, both chip selects and both strobes are high, `hostReady` is high and `hostDataOe` is low.
- R11: A request made while `hostReady` is low is dropped. It neither starts a drive cycle nor changes the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseSel | input | SEL_W (5) | Window base select |
| hostAddr | input | ADDR_W (10) | Host I/O address |
| hostRd | input | 1 | Host read request, one cycle |
| hostWr | input | 1 | Host write request, one cycle |
| hostWrData | input | DATA_W (8) | Host write byte |
| hostRdData | output | DATA_W (8) | Host read byte, valid with hostDataOe |
| hostDataOe | output | 1 | Block drives the host read bus this cycle |
| hostReady | output | 1 | Block can accept a request |
| ataAddr | output | 3 | Drive register address |
| ataCs0N | output | 1 | Command-block select, active low |
| ataCs1N | output | 1 | Control-block select, active low |
| ataRdN | output | 1 | Drive read strobe, active low |
| ataWrN | output | 1 | Drive write strobe, active low |
| ataDataOut | output | WORD_W (16) | Word driven to the drive |
| ataDataIn | input | WORD_W (16) | Word from the drive |
| ataDataOe | output | 1 | Block drives the drive data bus |

## Verification
The bench builds the bridge with `STROBE_CYC` set to 2, not the default 3. This shows that the strobe length and the busy window follow the parameter and are not fixed. It also makes the rise of the read strobe a separate edge from its first low cycle. The drive model offers the true word only in the last strobe clock, so a capture taken one edge early returns a decoy value. `baseSel` is moved across its lowest, middle and highest values so the window compare is exercised at both ends of the base range.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;

  // Class of a register offset inside the host window
  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_CTL   = 2'd1,
    KIND_LATCH = 2'd2,
    KIND_EMPTY = 2'd3
  } regKind_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadWord;     // latch an outgoing drive word
    logic localRd;      // answer a read locally (latch or 0xFF)
    logic localWr;      // write the high-byte latch
    logic capture;      // take the drive word into the read register
    logic captureHigh;  // also take bits [15:8] into the latch
    logic respond;      // a drive read completes this cycle
  } dpCtrl_t;

  localparam logic [3:0] LATCH_OFFSET   = 4'h8;
  localparam logic [3:0] CTL_OFFSET     = 4'hE;
  localparam logic [2:0] CTL_DRIVE_ADDR = 3'd6;

endpackage

// File: rtl/bridge_decode.sv
module bridge_decode
  import ata_bridge_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int SEL_W   = 5,
  parameter int BASE_LO = 'h200
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [SEL_W-1:0]  baseSel,
  output logic              hit,
  output regKind_t          kind,
  output logic [2:0]        drvAddr,
  output logic              isWordReg
);
  localparam int TAG_W = ADDR_W - 4;
  localparam logic [TAG_W-1:0] TAG_LO = TAG_W'(BASE_LO >> 4);

  logic [TAG_W-1:0] winTag;
  logic [3:0]       regOff;

  always_comb begin
    winTag    = TAG_LO + TAG_W'(baseSel);
    regOff    = hostAddr[3:0];
    hit       = (hostAddr[ADDR_W-1:4] == winTag);
    isWordReg = (regOff == 4'h0);
    if (!regOff[3])                  kind = KIND_CMD;
    else if (regOff == LATCH_OFFSET) kind = KIND_LATCH;
    else if (regOff == CTL_OFFSET)   kind = KIND_CTL;
    else                             kind = KIND_EMPTY;
    drvAddr = (kind == KIND_CTL) ? CTL_DRIVE_ADDR : regOff[2:0];
  end
endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import ata_bridge_pkg::*;
#(
  parameter int STROBE_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostRd,
  input  logic       hostWr,
  input  logic       hit,
  input  regKind_t   kind,
  input  logic [2:0] drvAddr,
  input  logic       isWordReg,
  output logic       hostReady,
  output logic [2:0] ataAddr,
  output logic       ataCs0N,
  output logic       ataCs1N,
  output logic       ataRdN,
  output logic       ataWrN,
  output logic       ataDataOe,
  output dpCtrl_t    dp
);
  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(STROBE_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] beat;
  logic             isRead, useCtl, isWord;
  logic [2:0]       addrReg;
  logic             idle, startRd, startWr, driveKind, startDrive, lastBeat;

  always_comb begin
    idle       = (phase == ST_IDLE);
    startRd    = idle && hit && hostRd && !hostWr;
    startWr    = idle && hit && hostWr && !hostRd;
    driveKind  = (kind == KIND_CMD) || (kind == KIND_CTL);
    startDrive = (startRd || startWr) && driveKind;
    lastBeat   = (beat == LAST_BEAT);

    dp.loadWord    = startWr && driveKind;
    dp.localRd     = startRd && !driveKind;
    dp.localWr     = startWr && (kind == KIND_LATCH);
    dp.capture     = (phase == ST_STROBE) && lastBeat && isRead;
    dp.captureHigh = dp.capture && isWord;
    dp.respond     = (phase == ST_HOLD) && isRead;

    hostReady = idle;
    ataAddr   = addrReg;
    ataCs0N   = idle || useCtl;
    ataCs1N   = idle || !useCtl;
    ataRdN    = !((phase == ST_STROBE) && isRead);
    ataWrN    = !((phase == ST_STROBE) && !isRead);
    ataDataOe = !idle && !isRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= ST_IDLE;
      beat    <= '0;
      isRead  <= 1'b0;
      useCtl  <= 1'b0;
      isWord  <= 1'b0;
      addrReg <= '0;
    end else begin
      unique case (phase)
        ST_IDLE: if (startDrive) begin
          phase   <= ST_SETUP;
          isRead  <= startRd;
          useCtl  <= (kind == KIND_CTL);
          isWord  <= isWordReg && (kind == KIND_CMD);
          addrReg <= drvAddr;
        end
        ST_SETUP: begin
          phase <= ST_STROBE;
          beat  <= '0;
        end
        ST_STROBE: begin
          if (lastBeat) phase <= ST_HOLD;
          else          beat  <= beat + 1'b1;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import ata_bridge_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dp,
  input  regKind_t          kind,
  input  logic              isWordReg,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [WORD_W-1:0] ataDataIn,
  output logic [WORD_W-1:0] ataDataOut,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostDataOe
);
  logic [DATA_W-1:0] hiLatch;
  logic [DATA_W-1:0] rdReg;
  logic [WORD_W-1:0] wordReg;
  logic              respValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiLatch   <= '0;
      rdReg     <= '0;
      wordReg   <= '0;
      respValid <= 1'b0;
    end else begin
      respValid <= dp.localRd || dp.respond;
      if (dp.localWr) hiLatch <= hostWrData;
      if (dp.captureHigh) hiLatch <= ataDataIn[WORD_W-1:DATA_W];
      if (dp.loadWord)
        wordReg <= {(isWordReg && kind == KIND_CMD) ? hiLatch : {DATA_W{1'b0}}, hostWrData};
      if (dp.localRd)
        rdReg <= (kind == KIND_LATCH) ? hiLatch : {DATA_W{1'b1}};
      if (dp.capture) rdReg <= ataDataIn[DATA_W-1:0];
    end
  end

  always_comb begin
    ataDataOut = wordReg;
    hostDataOe = respValid;
    hostRdData = respValid ? rdReg : '0;
  end
endmodule

// File: rtl/narrow_ata_bridge.sv
module narrow_ata_bridge
  import ata_bridge_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int SEL_W      = 5,
  parameter int BASE_LO    = 'h200,
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 3,
  localparam int WORD_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostDataOe,
  output logic              hostReady,
  output logic [2:0]        ataAddr,
  output logic              ataCs0N,
  output logic              ataCs1N,
  output logic              ataRdN,
  output logic              ataWrN,
  output logic [WORD_W-1:0] ataDataOut,
  input  logic [WORD_W-1:0] ataDataIn,
  output logic              ataDataOe
);
  logic       hit;
  regKind_t   kind;
  logic [2:0] drvAddr;
  logic       isWordReg;
  dpCtrl_t    dp;

  bridge_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .BASE_LO(BASE_LO)) i_decode (
    .hostAddr(hostAddr), .baseSel(baseSel), .hit(hit), .kind(kind),
    .drvAddr(drvAddr), .isWordReg(isWordReg)
  );

  bridge_ctrl #(.STROBE_CYC(STROBE_CYC)) i_ctrl (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr), .hit(hit),
    .kind(kind), .drvAddr(drvAddr), .isWordReg(isWordReg), .hostReady(hostReady),
    .ataAddr(ataAddr), .ataCs0N(ataCs0N), .ataCs1N(ataCs1N), .ataRdN(ataRdN),
    .ataWrN(ataWrN), .ataDataOe(ataDataOe), .dp(dp)
  );

  bridge_datapath #(.DATA_W(DATA_W), .WORD_W(WORD_W)) i_datapath (
    .clk(clk), .rstN(rstN), .dp(dp), .kind(kind), .isWordReg(isWordReg),
    .hostWrData(hostWrData), .ataDataIn(ataDataIn), .ataDataOut(ataDataOut),
    .hostRdData(hostRdData), .hostDataOe(hostDataOe)
  );
endmodule

// File: rtl/narrow_ata_bridge_chk.sv
module narrow_ata_bridge_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostReady,
  input logic [2:0]        ataAddr,
  input logic              ataCs0N,
  input logic              ataCs1N,
  input logic              ataRdN,
  input logic              ataWrN,
  input logic [WORD_W-1:0] ataDataOut,
  input logic              ataDataOe
);
  assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(!ataRdN && !ataWrN));

  assert_single_select_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(!ataCs0N && !ataCs1N));

  assert_ctl_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ataCs1N |-> (ataAddr == 3'd6));

  assert_setup_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ataRdN) || $fell(ataWrN)) |-> $past(!ataCs0N || !ataCs1N));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ataRdN) || $rose(ataWrN)) |-> (!ataCs0N || !ataCs1N));

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!ataRdN || !ataWrN) |-> !hostReady);

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(ataDataOe && !ataRdN));

  assert_word_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ataWrN && $past(!ataWrN)) |-> $stable(ataDataOut));
endmodule

bind narrow_ata_bridge narrow_ata_bridge_chk #(.WORD_W(WORD_W)) i_chk (
  .clk(clk), .rstN(rstN), .hostReady(hostReady), .ataAddr(ataAddr),
  .ataCs0N(ataCs0N), .ataCs1N(ataCs1N), .ataRdN(ataRdN), .ataWrN(ataWrN),
  .ataDataOut(ataDataOut), .ataDataOe(ataDataOe)
);

// File: tb/test_narrow_ata_bridge.sv
module test_narrow_ata_bridge;
  localparam int STROBE = 2;

  typedef struct packed {
    logic        wr;
    logic [3:0]  off;
    logic [7:0]  data;
    logic [15:0] drvIn;
    logic        drv;
    logic        ctl;
    logic [2:0]  addr;
    logic [15:0] word;
    logic        resp;
    logic [7:0]  rd;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 4'h8, 8'h3C, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 8'h00},
    '{1'b0, 4'h8, 8'h00, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 8'h3C},
    '{1'b1, 4'h0, 8'h11, 16'h0000, 1'b1, 1'b0, 3'd0, 16'h3C11, 1'b0, 8'h00},
    '{1'b0, 4'h0, 8'h00, 16'hBEEF, 1'b1, 1'b0, 3'd0, 16'h0000, 1'b1, 8'hEF},
    '{1'b0, 4'h8, 8'h00, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 8'hBE},
    '{1'b1, 4'h3, 8'h77, 16'h0000, 1'b1, 1'b0, 3'd3, 16'h0077, 1'b0, 8'h00},
    '{1'b0, 4'h7, 8'h00, 16'h1250, 1'b1, 1'b0, 3'd7, 16'h0000, 1'b1, 8'h50},
    '{1'b0, 4'h8, 8'h00, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 8'hBE},
    '{1'b1, 4'hE, 8'h04, 16'h0000, 1'b1, 1'b1, 3'd6, 16'h0004, 1'b0, 8'h00},
    '{1'b0, 4'hE, 8'h00, 16'h3381, 1'b1, 1'b1, 3'd6, 16'h0000, 1'b1, 8'h81},
    '{1'b0, 4'hB, 8'h00, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 8'hFF},
    '{1'b1, 4'hF, 8'h99, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b0, 8'h00},
    '{1'b0, 4'hD, 8'h00, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 8'hFF},
    '{1'b0, 4'h8, 8'h00, 16'h0000, 1'b0, 1'b0, 3'd0, 16'h0000, 1'b1, 8'hBE},
    '{1'b1, 4'h0, 8'h22, 16'h0000, 1'b1, 1'b0, 3'd0, 16'hBE22, 1'b0, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  baseSel = 5'h10;
  logic [9:0]  hostAddr = '0;
  logic        hostRd = 1'b0, hostWr = 1'b0;
  logic [7:0]  hostWrData = '0;
  logic [7:0]  hostRdData;
  logic        hostDataOe, hostReady;
  logic [2:0]  ataAddr;
  logic        ataCs0N, ataCs1N, ataRdN, ataWrN, ataDataOe;
  logic [15:0] ataDataOut, ataDataIn;

  int tests = 0, fails = 0;
  bit finished = 0;

  // Drive model: true word only in the last strobe clock, decoy otherwise
  logic [15:0] drvWord = '0;
  int rdLowCnt = 0;
  always @(posedge clk) rdLowCnt <= ataRdN ? 0 : rdLowCnt + 1;
  assign ataDataIn = (!ataRdN && rdLowCnt == STROBE - 1) ? drvWord : 16'h5A5A;

  always #5 clk = ~clk;

  narrow_ata_bridge #(.STROBE_CYC(STROBE)) i_narrow_ata_bridge (
    .clk(clk), .rstN(rstN), .baseSel(baseSel), .hostAddr(hostAddr),
    .hostRd(hostRd), .hostWr(hostWr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .hostDataOe(hostDataOe), .hostReady(hostReady),
    .ataAddr(ataAddr), .ataCs0N(ataCs0N), .ataCs1N(ataCs1N), .ataRdN(ataRdN),
    .ataWrN(ataWrN), .ataDataOut(ataDataOut), .ataDataIn(ataDataIn),
    .ataDataOe(ataDataOe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Observations from the last access
  int busy, csCyc, strobeCyc;
  bit sawDrv, sawCs1, sawResp, setupBad;
  logic [2:0]  sawAddr;
  logic [15:0] sawWord;
  logic [7:0]  sawRd;

  task automatic doAccess(input bit wr, input logic [9:0] addr, input logic [7:0] data,
                          input logic [15:0] drvIn, input bit intrude);
    bit firstCs;
    @(negedge clk);
    hostAddr = addr; hostWrData = data; hostWr = wr; hostRd = !wr; drvWord = drvIn;
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0;
    busy = 0; csCyc = 0; strobeCyc = 0; sawDrv = 0; sawCs1 = 0; sawResp = 0;
    setupBad = 0; sawAddr = '0; sawWord = '0; sawRd = '0; firstCs = 1;
    for (int i = 0; i < 10; i++) begin
      if (!hostReady) busy++;
      if (!ataCs0N || !ataCs1N) begin
        csCyc++; sawCs1 = !ataCs1N; sawAddr = ataAddr;
        if (firstCs && (!ataRdN || !ataWrN)) setupBad = 1;
        firstCs = 0;
      end
      if (!ataWrN) begin strobeCyc++; sawDrv = 1; sawWord = ataDataOut; end
      if (!ataRdN) begin strobeCyc++; sawDrv = 1; end
      if (hostDataOe) begin sawResp = 1; sawRd = hostRdData; end
      if (intrude && i == 1) begin
        hostWr = 1'b1; hostAddr = {addr[9:4], 4'h8}; hostWrData = 8'hAA;
      end
      if (intrude && i == 2) hostWr = 1'b0;
      @(negedge clk);
    end
  endtask

  function automatic string reqOf(input vec_t v);
    if (v.off == 4'h0)      return v.wr ? "R2" : "R3";
    else if (v.off == 4'h8) return "R4";
    else if (!v.off[3])     return "R5";
    else if (v.off == 4'hE) return "R6";
    else                    return "R7";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state at the ports
    check(hostReady == 1'b1, "R10 ready", hostReady, 1);
    check({ataCs0N, ataCs1N, ataRdN, ataWrN} == 4'hF, "R10 selects/strobes",
          {ataCs0N, ataCs1N, ataRdN, ataWrN}, 4'hF);
    check(hostDataOe == 1'b0, "R10 host bus idle", hostDataOe, 0);
    doAccess(1'b0, 10'h308, 8'h00, 16'h0, 1'b0);
    check(sawResp && sawRd == 8'h00, "R10 latch reset value", sawRd, 8'h00);

    // Vector table
    for (int k = 0; k < NVEC; k++) begin
      vec_t v;
      string tag;
      v = VECS[k];
      tag = reqOf(v);
      doAccess(v.wr, {6'h30, v.off}, v.data, v.drvIn, 1'b0);
      check(sawDrv == v.drv, {tag, " drive access"}, sawDrv, v.drv);
      check(busy == (v.drv ? STROBE + 2 : 0), "R8 busy window", busy, v.drv ? STROBE + 2 : 0);
      if (v.drv) begin
        check(csCyc == STROBE + 2 && strobeCyc == STROBE && !setupBad, "R8 sequence",
              csCyc * 256 + strobeCyc, (STROBE + 2) * 256 + STROBE);
        check(sawCs1 == v.ctl && sawAddr == v.addr, {tag, " select/address"},
              {sawCs1, sawAddr}, {v.ctl, v.addr});
        if (v.wr) check(sawWord == v.word, {tag, " drive word"}, sawWord, v.word);
      end
      check(sawResp == v.resp, {tag, " response present"}, sawResp, v.resp);
      if (v.resp)
        check(sawRd == v.rd, {tag, (v.drv ? " R9 captured byte" : " read byte")}, sawRd, v.rd);
    end

    // R1: out-of-window accesses, then base at both ends
    doAccess(1'b0, 10'h2F8, 8'h00, 16'h0, 1'b0);
    check(!sawResp && !sawDrv && busy == 0, "R1 outside read ignored", {sawResp, sawDrv}, 0);
    doAccess(1'b1, 10'h318, 8'h55, 16'h0, 1'b0);
    check(!sawDrv, "R1 outside write ignored", sawDrv, 0);
    doAccess(1'b0, 10'h308, 8'h00, 16'h0, 1'b0);
    check(sawRd == 8'hBE, "R1 latch untouched by outside write", sawRd, 8'hBE);
    baseSel = 5'h00;
    doAccess(1'b0, 10'h208, 8'h00, 16'h0, 1'b0);
    check(sawResp && sawRd == 8'hBE, "R1 base 0x200", sawRd, 8'hBE);
    baseSel = 5'h1F;
    doAccess(1'b1, 10'h3F8, 8'h66, 16'h0, 1'b0);
    doAccess(1'b0, 10'h3F8, 8'h00, 16'h0, 1'b0);
    check(sawResp && sawRd == 8'h66, "R1 base 0x3F0", sawRd, 8'h66);
    doAccess(1'b0, 10'h308, 8'h00, 16'h0, 1'b0);
    check(!sawResp, "R1 old base no longer answers", sawResp, 0);

    // R11: latch write during a busy drive read is dropped
    baseSel = 5'h10;
    doAccess(1'b0, 10'h301, 8'h00, 16'h00C3, 1'b1);
    check(sawResp && sawRd == 8'hC3, "R11 read still completes", sawRd, 8'hC3);
    doAccess(1'b0, 10'h308, 8'h00, 16'h0, 1'b0);
    check(sawRd == 8'h66, "R11 latch unchanged by busy request", sawRd, 8'h66);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule